// File: doc/BRIEF.md
# TDMA Slot and Round Sequencer

This block keeps a local time base and walks a static time-division schedule. Each clock cycle is one microtick. A programmable divider turns microticks into macroticks, and every macrotick advances a global time counter. A schedule table holds one entry per slot. Each entry gives the slot length in macroticks and the identifier of the node that may send in that slot. The table is written while the sequencer is idle and is then frozen.

Once enabled, the block steps through the configured slots to form a round. It counts rounds up to the configured cluster-cycle length and then starts the whole schedule again from slot 0 of round 0. When the current slot belongs to the local node, a transmit-window flag is raised for the full length of that slot. The host sees three strobes: a macrotick pulse on each global time increment, an overflow pulse when global time wraps to zero, and a microtick indicator. Each of the three indicator pins can instead be switched to drive a general-purpose output bit.

The controller has two states. SEQ_IDLE holds every counter at zero and accepts table writes. SEQ_RUN sequences the schedule. The transition SEQ_IDLE to SEQ_RUN is taken on a clock edge where `enable` is high. The transition SEQ_RUN to SEQ_IDLE is taken on a clock edge where `enable` is low.

Top module: `tdma_sequencer`

## Requirements
- R1: In SEQ_IDLE, `slot_idx`, `round_idx` and `gtime` are zero, `tx_window`, `macro_tick`-driven and overflow strobes are low, and schedule writes (`sched_we`) store `sched_len`/`sched_node` at entry `sched_addr`.
- R2: Schedule writes presented while in SEQ_RUN leave the table unchanged.
- R3: While running, a macrotick occurs every `cfg_div`+1 clock cycles. On the cycle after each macrotick, `gtime` has incremented by one, modulo 2^GT_W. `gtime` does not change between macroticks.
- R4: A slot whose entry holds length value L lasts L+1 macroticks. `slot_start` is high for exactly one cycle at the start of each slot, including the first cycle of SEQ_RUN.
- R5: After slot index `cfg_last_slot`, the slot index returns to 0 and `round_idx` advances. After round `cfg_last_round`, `round_idx` returns to 0, so the cluster cycle repeats.
- R6: `tx_window` is high exactly while the state is SEQ_RUN and the current slot's sender equals `local_node`.
- R7: The overflow strobe is high for one cycle when `gtime` wraps from all ones to zero, and it coincides with the macrotick strobe.
- R8: `led_out[i]` equals `led_gpo[i]` when `led_mode[i]` is 1. Otherwise bit 0 is the microtick indicator (toggles every running cycle, 0 in idle), bit 1 is the macrotick strobe and bit 2 is the overflow strobe.
- R9: Dropping `enable` returns the block to SEQ_IDLE with all counters cleared. Re-enabling starts again at slot 0, round 0, global time 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microtick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request for the sequencer |
| cfg_div | input | DIV_W | Microticks per macrotick minus one |
| cfg_last_slot | input | IDX_W | Index of the last slot in a round |
| cfg_last_round | input | ROUND_W | Index of the last round in a cluster cycle |
| local_node | input | NODE_W | Identifier of this node |
| sched_we | input | 1 | Schedule table write strobe |
| sched_addr | input | IDX_W | Schedule entry written |
| sched_len | input | LEN_W | Slot length in macroticks minus one |
| sched_node | input | NODE_W | Sending node of the slot |
| led_mode | input | 3 | Per-pin select: 1 = general-purpose bit |
| led_gpo | input | 3 | General-purpose output values |
| slot_idx | output | IDX_W | Current slot in the round |
| round_idx | output | ROUND_W | Current round in the cluster cycle |
| slot_start | output | 1 | One-cycle strobe at each slot start |
| tx_window | output | 1 | Local node may transmit |
| gtime | output | GT_W | Global time in macroticks |
| led_out | output | 3 | Microtick / macrotick / overflow indicators or GPO |

## Verification
The schedule is tried with uneven slot lengths and a divide ratio of two. This shows whether slot ends are counted in macroticks rather than microticks, and whether the wrap from the last slot into a new round and from the last round into a new cluster cycle happens at the right edge. A second pattern has one single-slot round and a divide ratio of one. It drives global time through its wrap to zero, which separates the overflow strobe from the ordinary macrotick. A write during SEQ_RUN that names a foreign sender for a local slot would show up as a change in the transmit window, so an accepted write is caught. Dropping `enable` in mid-round and enabling again shows whether the restart from zero is complete. Mixed pin-select patterns separate the general-purpose path from each indicator.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/tdma_sched_mem.sv
module tdma_sched_mem #(
    parameter int SLOTS  = 16,
    parameter int IDX_W  = 4,
    parameter int LEN_W  = 8,
    parameter int NODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [NODE_W-1:0] wr_node,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [LEN_W-1:0]  rd_len,
    output logic [NODE_W-1:0] rd_node
);
    logic [LEN_W-1:0]  len_q  [SLOTS];
    logic [NODE_W-1:0] node_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_q[g]  <= '0;
                node_q[g] <= '0;
            end else if (wr_en && wr_addr == IDX_W'(g)) begin
                len_q[g]  <= wr_len;
                node_q[g] <= wr_node;
            end
        end
    end

    assign rd_len  = len_q[rd_addr];
    assign rd_node = node_q[rd_addr];
endmodule

// File: rtl/tdma_mtick_div.sv
module tdma_mtick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == ratio);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else if (tick)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tdma_sequencer.sv
module tdma_sequencer #(
    parameter int SLOTS   = 16,
    parameter int NODE_W  = 4,
    parameter int LEN_W   = 8,
    parameter int ROUND_W = 4,
    parameter int DIV_W   = 8,
    parameter int GT_W    = 16,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [IDX_W-1:0]   cfg_last_slot,
    input  logic [ROUND_W-1:0] cfg_last_round,
    input  logic [NODE_W-1:0]  local_node,
    input  logic               sched_we,
    input  logic [IDX_W-1:0]   sched_addr,
    input  logic [LEN_W-1:0]   sched_len,
    input  logic [NODE_W-1:0]  sched_node,
    input  logic [2:0]         led_mode,
    input  logic [2:0]         led_gpo,
    output logic [IDX_W-1:0]   slot_idx,
    output logic [ROUND_W-1:0] round_idx,
    output logic               slot_start,
    output logic               tx_window,
    output logic [GT_W-1:0]    gtime,
    output logic [2:0]         led_out
);
    import tdma_pkg::*;

    seq_state_t         state_q, state_d;
    logic               run_q;
    logic               active;
    logic               mtick;
    logic               slot_end;
    logic [LEN_W-1:0]   cur_len;
    logic [NODE_W-1:0]  cur_node;
    logic [LEN_W-1:0]   mk_cnt_q;
    logic               macro_q, ovf_q, utog_q;
    logic [2:0]         ind;

    assign run_q  = (state_q == SEQ_RUN);
    assign active = run_q && enable;

    tdma_sched_mem #(
        .SLOTS(SLOTS), .IDX_W(IDX_W), .LEN_W(LEN_W), .NODE_W(NODE_W)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sched_we && !run_q),
        .wr_addr (sched_addr),
        .wr_len  (sched_len),
        .wr_node (sched_node),
        .rd_addr (slot_idx),
        .rd_len  (cur_len),
        .rd_node (cur_node)
    );

    tdma_mtick_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .ratio (cfg_div),
        .tick  (mtick)
    );

    assign slot_end = (mk_cnt_q == cur_len);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (enable)  state_d = SEQ_RUN;
            SEQ_RUN:  if (!enable) state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // outputs and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_idx   <= '0;
            round_idx  <= '0;
            gtime      <= '0;
            mk_cnt_q   <= '0;
            slot_start <= 1'b0;
            macro_q    <= 1'b0;
            ovf_q      <= 1'b0;
            utog_q     <= 1'b0;
        end else if (!active) begin
            slot_idx   <= '0;
            round_idx  <= '0;
            gtime      <= '0;
            mk_cnt_q   <= '0;
            slot_start <= !run_q && enable;
            macro_q    <= 1'b0;
            ovf_q      <= 1'b0;
            utog_q     <= 1'b0;
        end else begin
            utog_q     <= ~utog_q;
            macro_q    <= mtick;
            ovf_q      <= mtick && (&gtime);
            slot_start <= mtick && slot_end;
            if (mtick) begin
                gtime <= gtime + 1'b1;
                if (slot_end) begin
                    mk_cnt_q <= '0;
                    if (slot_idx == cfg_last_slot) begin
                        slot_idx <= '0;
                        if (round_idx == cfg_last_round) round_idx <= '0;
                        else                             round_idx <= round_idx + 1'b1;
                    end else begin
                        slot_idx <= slot_idx + 1'b1;
                    end
                end else begin
                    mk_cnt_q <= mk_cnt_q + 1'b1;
                end
            end
        end
    end

    assign tx_window = run_q && (cur_node == local_node);

    assign ind = {ovf_q, macro_q, utog_q};
    for (genvar i = 0; i < 3; i++) begin : g_led
        assign led_out[i] = led_mode[i] ? led_gpo[i] : ind[i];
    end
endmodule

// File: rtl/tdma_sequencer_chk.sv
module tdma_sequencer_chk #(
    parameter int IDX_W   = 4,
    parameter int ROUND_W = 4,
    parameter int GT_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_q,
    input logic               macro_q,
    input logic               ovf_q,
    input logic               slot_start,
    input logic               tx_window,
    input logic [IDX_W-1:0]   slot_idx,
    input logic [ROUND_W-1:0] round_idx,
    input logic [GT_W-1:0]    gtime
);
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (slot_idx == '0 && round_idx == '0 && gtime == '0 && !macro_q && !ovf_q)); // R1

    AST_GT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        macro_q |-> gtime == GT_W'($past(gtime) + 1'b1)); // R3

    AST_GT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !macro_q) |-> $stable(gtime)); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (macro_q && gtime == '0)); // R7

    AST_SLOT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && $past(run_q)) |-> macro_q); // R4

    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && round_idx != $past(round_idx)) |-> (slot_start && slot_idx == '0)); // R5

    AST_TX_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_window |-> run_q); // R6
endmodule

bind tdma_sequencer tdma_sequencer_chk #(
    .IDX_W(IDX_W), .ROUND_W(ROUND_W), .GT_W(GT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_q      (run_q),
    .macro_q    (macro_q),
    .ovf_q      (ovf_q),
    .slot_start (slot_start),
    .tx_window  (tx_window),
    .slot_idx   (slot_idx),
    .round_idx  (round_idx),
    .gtime      (gtime)
);

// File: tb/sim_tdma_sequencer.sv
module sim_tdma_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS   = 16;
    localparam int NODE_W  = 4;
    localparam int LEN_W   = 8;
    localparam int ROUND_W = 4;
    localparam int DIV_W   = 8;
    localparam int GT_W    = 8;
    localparam int IDX_W   = $clog2(SLOTS);
    localparam int GT_MAX  = (1 << GT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               enable = 1'b0;
    logic [DIV_W-1:0]   cfg_div = '0;
    logic [IDX_W-1:0]   cfg_last_slot = '0;
    logic [ROUND_W-1:0] cfg_last_round = '0;
    logic [NODE_W-1:0]  local_node = '0;
    logic               sched_we = 1'b0;
    logic [IDX_W-1:0]   sched_addr = '0;
    logic [LEN_W-1:0]   sched_len = '0;
    logic [NODE_W-1:0]  sched_node = '0;
    logic [2:0]         led_mode = '0;
    logic [2:0]         led_gpo = '0;
    logic [IDX_W-1:0]   slot_idx;
    logic [ROUND_W-1:0] round_idx;
    logic               slot_start;
    logic               tx_window;
    logic [GT_W-1:0]    gtime;
    logic [2:0]         led_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdma_sequencer #(
        .SLOTS(SLOTS), .NODE_W(NODE_W), .LEN_W(LEN_W),
        .ROUND_W(ROUND_W), .DIV_W(DIV_W), .GT_W(GT_W)
    ) u0 (.*);

    int vectors = 0;
    int fails = 0;
    string ctx = "R1";

    // behavioural reference state
    int  m_len[SLOTS];
    int  m_node[SLOTS];
    bit  m_run = 0;
    int  m_mt = 0, m_mk = 0, m_slot = 0, m_round = 0, m_gt = 0;
    bit  m_macro = 0, m_ovf = 0, m_start = 0, m_tog = 0;
    int  ovf_seen = 0, start_seen = 0, round_wraps = 0;

    task automatic clear_model();
        m_mt = 0; m_mk = 0; m_slot = 0; m_round = 0; m_gt = 0;
        m_macro = 0; m_ovf = 0; m_tog = 0;
    endtask

    task automatic predict();
        bit was_run = m_run;
        if (sched_we && !was_run) begin
            m_len[sched_addr]  = sched_len;
            m_node[sched_addr] = sched_node;
        end
        if (!was_run || !enable) begin
            clear_model();
            m_start = !was_run && enable;
            m_run = enable;
        end else begin
            bit t = (m_mt == cfg_div);
            m_tog = !m_tog;
            m_mt = t ? 0 : m_mt + 1;
            m_macro = t;
            m_ovf = t && (m_gt == GT_MAX);
            m_start = 0;
            if (t) begin
                m_gt = (m_gt + 1) & GT_MAX;
                if (m_mk == m_len[m_slot]) begin
                    m_mk = 0;
                    m_start = 1;
                    if (m_slot == cfg_last_slot) begin
                        m_slot = 0;
                        if (m_round == cfg_last_round) begin
                            m_round = 0;
                            round_wraps++;
                        end else m_round++;
                    end else m_slot++;
                end else m_mk++;
            end
        end
    endtask

    task automatic chk(string what, string req, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s [%s] actual=%0d expected=%0d t=%0t", req, what, ctx, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit [2:0] ind;
        bit [2:0] led_exp;
        vectors++;
        ind = {m_ovf, m_macro, m_tog};
        for (int i = 0; i < 3; i++) led_exp[i] = led_mode[i] ? led_gpo[i] : ind[i];
        chk("slot_idx",   "R5", slot_idx,   m_slot);
        chk("round_idx",  "R5", round_idx,  m_round);
        chk("gtime",      "R3", gtime,      m_gt);
        chk("slot_start", "R4", slot_start, m_start);
        chk("tx_window",  "R6", tx_window,  m_run && (m_node[m_slot] == local_node));
        chk("led_out",    "R8", led_out,    led_exp);
        if (m_ovf) ovf_seen++;
        if (m_start) start_seen++;
    endtask

    task automatic cyc(int n = 1);
        for (int k = 0; k < n; k++) begin
            predict();
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic load(int a, int l, int nd);
        sched_we = 1; sched_addr = IDX_W'(a); sched_len = LEN_W'(l); sched_node = NODE_W'(nd);
        cyc();
        sched_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin m_len[i] = 0; m_node[i] = 0; end
        repeat (3) @(negedge clk);
        ctx = "R1 reset";
        compare();
        rst_n = 1;

        // R1: table load in idle
        ctx = "R1 load";
        local_node = 4'd1;
        load(0, 2, 1);
        load(1, 0, 3);
        load(2, 3, 1);
        load(3, 1, 5);
        cyc(3);

        // uneven slots, divide by two, three rounds per cluster cycle (R4, R5, R6)
        ctx = "R5 run";
        cfg_div = 8'd1; cfg_last_slot = 4'd3; cfg_last_round = 4'd2;
        enable = 1;
        cyc(40);

        // R2: write during run must be ignored
        ctx = "R2";
        sched_we = 1; sched_addr = 4'd0; sched_node = 4'd7; sched_len = 8'd9;
        cyc(2);
        sched_we = 0;
        cyc(200);
        chk("cluster wraps seen", "R5", int'(round_wraps > 0), 1);

        // R9: drop enable mid-round and restart
        ctx = "R9";
        enable = 0;
        cyc(4);
        enable = 1;
        cyc(60);
        enable = 0;
        cyc(2);

        // R7: single-slot round, divide by one, run global time through its wrap
        ctx = "R7";
        cfg_div = 8'd0; cfg_last_slot = 4'd0; cfg_last_round = 4'd3;
        local_node = 4'd2;
        enable = 1;
        cyc(GT_MAX + 20);
        chk("overflow seen", "R7", int'(ovf_seen > 0), 1);

        // R8: pin select patterns
        ctx = "R8";
        led_mode = 3'b101; led_gpo = 3'b111;
        cyc(6);
        led_mode = 3'b010; led_gpo = 3'b000;
        cyc(6);
        led_mode = 3'b111; led_gpo = 3'b010;
        cyc(3);
        led_mode = 3'b000;
        cyc(3);

        ctx = "R1 idle";
        enable = 0;
        cyc(5);
        chk("slot starts seen", "R4", int'(start_seen > 10), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule